// File: doc/BRIEF.md
# Prescaled 16-bit Event Counter with Coherent Byte Readout

This block is a free-running 16-bit up-counter for a small microcontroller. Software reaches it through an 8-bit register bus with four addresses: the count's low byte, its high byte, a mode register and a control register. The counter always runs on the system clock. It advances by one on each single-cycle timebase event, and a 3-bit mode field chooses where those events come from. The sources are two fixed prescalers of the system clock, the system clock itself, a pulse from another timer's overflow, falling edges on an external count pin, and rising edges of an externally divided clock. Both external signals are synchronized before use.

A read of the low byte copies the live high byte into a shadow register. The read of the high-byte address that follows returns that shadow, so software can assemble a 16-bit value from two byte reads even while the counter runs. When the count wraps to zero, a sticky overflow flag is set. Only software clears it. The flag drives an interrupt request, gated by a local enable, a block-level enable and a global enable. A run bit gates counting. An idle-freeze bit can also stop counting while the CPU reports idle. Byte writes load the live counter directly.

Top module: `snapctr_top`

## Requirements
- R1: After reset, all four registers read 0x00 and irq_o is 0.
- R2: Address 0 reads the live low byte, and the same read copies the live high byte into a snapshot. Address 1 reads the snapshot, not the live high byte.
- R3: Register reads never stall, reset or change the count.
- R4: Timebase field = mode bits [3:1]. 000 advances once per 12 system clocks, 001 once per 4, and 100 on every system clock. 110 and 111 never advance the count.
- R5: Code 010 advances once per single-cycle pulse on tmr_ovf_in.
- R6: Code 011 advances once per high-to-low transition of ext_cnt_in, seen after a two-flop synchronizer. Low-to-high transitions do not count.
- R7: Code 101 advances once per low-to-high transition of ext_clk_div, seen after a two-flop synchronizer.
- R8: An advance from 0xFFFF to 0x0000 sets the overflow flag, which is control register (address 3) bit 7.
- R9: The overflow flag stays set until software writes 0 to control bit 7. A wrap in the same cycle as that write leaves the flag set.
- R10: irq_o is 1 exactly when the overflow flag, mode bit 0 (local enable), blk_irq_en and glb_irq_en are all 1.
- R11: Counting happens only while control bit 6 (run) is 1. While mode bit 7 (idle freeze) and cpu_idle are both 1, the count holds. With mode bit 7 at 0, cpu_idle has no effect.
- R12: A write to address 0 or address 1 loads that byte of the live count. In that cycle the write takes the place of an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 mode, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a low-byte read captures the snapshot) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_cnt_in | input | 1 | Asynchronous external count pin |
| ext_clk_div | input | 1 | Asynchronous divided external clock |
| tmr_ovf_in | input | 1 | Single-cycle overflow pulse from another timer |
| cpu_idle | input | 1 | CPU idle indication |
| blk_irq_en | input | 1 | Block-level interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| count_o | output | 16 | Live count for downstream compare logic |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The count is driven through timed windows with every timebase code. The prescaler windows are whole multiples of the divide ratio, so the result does not depend on prescaler phase, and a /4 versus /12 mix-up shows as 10 against 4. The external pin gets square pulses, which makes falling-edge counting differ from rising-edge or level counting. The divided clock is checked on rising edges and the timer input on single pulses. A run starting at 0x00F8 reads low and high bytes on alternate cycles across the carry into the high byte, which separates snapshot readout from live readout. Writes and flag clears are timed to land on the exact increment or wrap cycle.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    typedef enum logic [2:0] {
        TB_DIV_SLOW = 3'b000,
        TB_DIV_FAST = 3'b001,
        TB_TMR_OVF  = 3'b010,
        TB_EXT_FALL = 3'b011,
        TB_SYSCLK   = 3'b100,
        TB_XCLK     = 3'b101,
        TB_RSV_A    = 3'b110,
        TB_RSV_B    = 3'b111
    } timebase_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_LO = 2'd0,
        RA_CNT_HI = 2'd1,
        RA_MODE   = 2'd2,
        RA_CTRL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic      idle_freeze;
        timebase_e tsel;
        logic      ovf_ie;
    } mode_t;

    typedef struct packed {
        logic ovf_flag;
        logic run;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pack_mode(mode_t m);
        return {m.idle_freeze, 3'b000, m.tsel, m.ovf_ie};
    endfunction

    function automatic mode_t unpack_mode(logic [BYTE_W-1:0] b);
        mode_t m;
        m.idle_freeze = b[7];
        m.tsel        = timebase_e'(b[3:1]);
        m.ovf_ie      = b[0];
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_t c);
        return {c.ovf_flag, c.run, 6'b000000};
    endfunction

endpackage

// File: rtl/snapctr_prescale.sv
module snapctr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                 phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign tick_o = (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            AST_PRESC_GAP: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o); // R4
        end
    endgenerate
endmodule

// File: rtl/snapctr_sync_edge.sv
module snapctr_sync_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic pulse_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign cur = sync_q[STAGES-1];

    generate
        if (FALLING) begin : g_fall
            assign pulse_o = prev_q & ~cur;
        end else begin : g_rise
            assign pulse_o = ~prev_q & cur;
        end
    endgenerate

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R6
endmodule

// File: rtl/snapctr_timebase.sv
module snapctr_timebase
    import snapctr_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  timebase_e tsel,
    input  logic      ext_cnt_in,
    input  logic      ext_clk_div,
    input  logic      tmr_ovf_in,
    output logic      tick_o
);
    logic slow_tick, fast_tick, fall_tick, xclk_tick;

    snapctr_prescale #(.DIV(DIV_SLOW)) u_slow (
        .clk(clk), .rst(rst), .tick_o(slow_tick));

    snapctr_prescale #(.DIV(DIV_FAST)) u_fast (
        .clk(clk), .rst(rst), .tick_o(fast_tick));

    snapctr_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_pin (
        .clk(clk), .rst(rst), .async_i(ext_cnt_in), .pulse_o(fall_tick));

    snapctr_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_xclk (
        .clk(clk), .rst(rst), .async_i(ext_clk_div), .pulse_o(xclk_tick));

    always_comb begin
        unique case (tsel)
            TB_DIV_SLOW: tick_o = slow_tick;
            TB_DIV_FAST: tick_o = fast_tick;
            TB_TMR_OVF:  tick_o = tmr_ovf_in;
            TB_EXT_FALL: tick_o = fall_tick;
            TB_SYSCLK:   tick_o = 1'b1;
            TB_XCLK:     tick_o = xclk_tick;
            default:     tick_o = 1'b0;
        endcase
    end

    AST_RSV_SILENT: assert property (@(posedge clk) disable iff (rst)
        (tsel == TB_RSV_A || tsel == TB_RSV_B) |-> !tick_o); // R4
endmodule

// File: rtl/snapctr_core.sv
module snapctr_core #(
    parameter int BW = 8,
    parameter int W  = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          wr_lo_i,
    input  logic          wr_hi_i,
    input  logic [BW-1:0] wdata_i,
    output logic [W-1:0]  cnt_o,
    output logic          wrap_o
);
    logic [W-1:0] cnt_q;
    logic         any_wr;

    assign any_wr = wr_lo_i | wr_hi_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo_i) cnt_q[BW-1:0] <= wdata_i;
            if (wr_hi_i) cnt_q[W-1:BW] <= wdata_i;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i & ~any_wr & (&cnt_q);

    AST_WR_LO_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_lo_i |=> cnt_o[BW-1:0] == $past(wdata_i)); // R12
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_o == '0); // R8
endmodule

// File: rtl/snapctr_top.sv
module snapctr_top
    import snapctr_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_cnt_in,
    input  logic              ext_clk_div,
    input  logic              tmr_ovf_in,
    input  logic              cpu_idle,
    input  logic              blk_irq_en,
    input  logic              glb_irq_en,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o
);
    mode_t             mode_q;
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] snap_q;
    logic              wr_lo, wr_hi, wr_mode, wr_ctrl, rd_lo;
    logic              tb_tick, gated_tick, wrap;
    logic              frozen;

    assign wr_lo   = bus_wr && (reg_addr_e'(bus_addr) == RA_CNT_LO);
    assign wr_hi   = bus_wr && (reg_addr_e'(bus_addr) == RA_CNT_HI);
    assign wr_mode = bus_wr && (reg_addr_e'(bus_addr) == RA_MODE);
    assign wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == RA_CTRL);
    assign rd_lo   = bus_rd && (reg_addr_e'(bus_addr) == RA_CNT_LO);

    snapctr_timebase #(
        .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .SYNC_STAGES(SYNC_STAGES)
    ) u_tb (
        .clk(clk), .rst(rst), .tsel(mode_q.tsel),
        .ext_cnt_in(ext_cnt_in), .ext_clk_div(ext_clk_div),
        .tmr_ovf_in(tmr_ovf_in), .tick_o(tb_tick));

    assign frozen     = !ctrl_q.run || (mode_q.idle_freeze && cpu_idle);
    assign gated_tick = tb_tick && !frozen;

    snapctr_core #(.BW(BYTE_W), .W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick_i(gated_tick),
        .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(bus_wdata),
        .cnt_o(count_o), .wrap_o(wrap));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctrl_q <= '0;
            snap_q <= '0;
        end else begin
            if (wr_mode) mode_q <= unpack_mode(bus_wdata);
            if (wr_ctrl) ctrl_q.run <= bus_wdata[6];
            if (wrap)         ctrl_q.ovf_flag <= 1'b1;
            else if (wr_ctrl) ctrl_q.ovf_flag <= bus_wdata[7];
            if (rd_lo) snap_q <= count_o[CNT_W-1:BYTE_W];
        end
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            RA_CNT_LO: bus_rdata = count_o[BYTE_W-1:0];
            RA_CNT_HI: bus_rdata = snap_q;
            RA_MODE:   bus_rdata = pack_mode(mode_q);
            default:   bus_rdata = pack_ctrl(ctrl_q);
        endcase
    end

    assign irq_o = ctrl_q.ovf_flag & mode_q.ovf_ie & blk_irq_en & glb_irq_en;

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> snap_q == $past(count_o[CNT_W-1:BYTE_W])); // R2
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !tb_tick) |=> $stable(count_o)); // R3
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ctrl_q.ovf_flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf_flag && !wr_ctrl) |=> ctrl_q.ovf_flag); // R9
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ctrl_q.ovf_flag && blk_irq_en && glb_irq_en)); // R10
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_lo && !wr_hi) |=> $stable(count_o)); // R11
endmodule

// File: tb/snapctr_top_tb.sv
`timescale 1ns/1ps
module snapctr_top_tb;
    import snapctr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_cnt_in = 1'b0, ext_clk_div = 1'b0, tmr_ovf_in = 1'b0;
    logic        cpu_idle = 1'b0, blk_irq_en = 1'b0, glb_irq_en = 1'b0;
    logic [15:0] count_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    snapctr_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_cnt_in(ext_cnt_in), .ext_clk_div(ext_clk_div),
        .tmr_ovf_in(tmr_ovf_in), .cpu_idle(cpu_idle),
        .blk_irq_en(blk_irq_en), .glb_irq_en(glb_irq_en),
        .count_o(count_o), .irq_o(irq_o));

    function automatic logic [7:0] mb(logic idle, logic [2:0] ts, logic ie);
        return {idle, 3'b000, ts, ie};
    endfunction

    // monitor: pops expected read data and compares at the falling edge
    always @(negedge clk) begin
        if (bus_rd) begin
            sb_item_t it;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty addr=%0d actual=%02h expected=none", bus_addr, bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (it.addr != bus_addr || it.exp != bus_rdata) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] e, string tag);
        sb_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_count(logic [15:0] e, string tag);
        rd_chk(2'd0, e[7:0], tag);
        rd_chk(2'd1, e[15:8], tag);
    endtask

    task automatic set_count(logic [15:0] v);
        bus_write(2'd0, v[7:0]);
        bus_write(2'd1, v[15:8]);
    endtask

    task automatic chk_irq(logic e, string tag);
        @(negedge clk);
        n_chk++;
        if (irq_o !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_o, e);
        end
        @(posedge clk); #1;
    endtask

    // counting window of k edges: start with one mode write, stop with another
    task automatic window(int k, logic [7:0] start_m, logic [7:0] stop_m);
        bus_write(2'd2, start_m);
        repeat (k - 1) @(posedge clk);
        #1;
        bus_write(2'd2, stop_m);
    endtask

    task automatic finish_run();
        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    localparam logic [7:0] STOP = 8'h0C; // tsel 110 reserved

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset values
        rd_chk(2'd0, 8'h00, "R1 lo");
        rd_chk(2'd1, 8'h00, "R1 hi");
        rd_chk(2'd2, 8'h00, "R1 mode");
        rd_chk(2'd3, 8'h00, "R1 ctrl");
        chk_irq(1'b0, "R1");

        // R12 byte loads, R2 snapshot vs live high byte
        set_count(16'h34AB);
        rd_chk(2'd0, 8'hAB, "R12 lo load");
        bus_write(2'd1, 8'h77);
        rd_chk(2'd1, 8'h34, "R2 snapshot kept");
        rd_chk(2'd0, 8'hAB, "R2 lo");
        rd_chk(2'd1, 8'h77, "R2 new snapshot");

        // R11 run=0 blocks counting
        window(20, mb(0, 3'b100, 0), STOP);
        chk_count(16'h77AB, "R11 run off");
        bus_write(2'd3, 8'h40);
        rd_chk(2'd3, 8'h40, "R11 run bit");

        // R4 system clock
        set_count(16'h0000);
        window(20, mb(0, 3'b100, 0), STOP);
        chk_count(16'h0014, "R4 sysclk");

        // R3 R2 interleaved reads while counting across the carry
        set_count(16'h00F8);
        bus_write(2'd2, mb(0, 3'b100, 0));
        for (int i = 0; i < 15; i++) begin
            if (i % 2 == 0) rd_chk(2'd0, 8'(16'h00F8 + i), "R3 live lo");
            else            rd_chk(2'd1, 8'((16'h00F8 + i - 1) >> 8), "R2 coherent hi");
        end
        bus_write(2'd2, STOP);
        chk_count(16'h0108, "R3 reads undisturbed");

        // R4 prescalers and reserved codes
        set_count(16'h0000);
        window(40, mb(0, 3'b001, 0), STOP);
        chk_count(16'h000A, "R4 div4");
        set_count(16'h0000);
        window(48, mb(0, 3'b000, 0), STOP);
        chk_count(16'h0004, "R4 div12");
        window(20, mb(0, 3'b111, 0), STOP);
        chk_count(16'h0004, "R4 reserved 111");

        // R5 timer overflow pulses
        set_count(16'h0000);
        bus_write(2'd2, mb(0, 3'b010, 0));
        for (int i = 0; i < 7; i++) begin
            tmr_ovf_in = 1'b1; @(posedge clk); #1;
            tmr_ovf_in = 1'b0; repeat (2) @(posedge clk); #1;
        end
        bus_write(2'd2, STOP);
        chk_count(16'h0007, "R5 timer pulses");

        // R6 falling edges on the pin only
        set_count(16'h0000);
        bus_write(2'd2, mb(0, 3'b011, 0));
        for (int i = 0; i < 5; i++) begin
            ext_cnt_in = 1'b1; repeat (4) @(posedge clk); #1;
            ext_cnt_in = 1'b0; repeat (4) @(posedge clk); #1;
        end
        ext_cnt_in = 1'b1; repeat (6) @(posedge clk); #1;
        bus_write(2'd2, STOP);
        chk_count(16'h0005, "R6 falling edges");

        // R7 rising edges of divided external clock
        set_count(16'h0000);
        bus_write(2'd2, mb(0, 3'b101, 0));
        for (int i = 0; i < 12; i++) begin
            ext_clk_div = ~ext_clk_div; repeat (3) @(posedge clk); #1;
        end
        repeat (6) @(posedge clk); #1;
        bus_write(2'd2, STOP);
        chk_count(16'h0006, "R7 xclk rising");

        // R11 idle freeze
        set_count(16'h0000);
        cpu_idle = 1'b1;
        window(20, mb(1, 3'b100, 0), STOP);
        chk_count(16'h0000, "R11 idle frozen");
        window(20, mb(0, 3'b100, 0), STOP);
        chk_count(16'h0014, "R11 idle ignored");
        cpu_idle = 1'b0;

        // R8 wrap sets flag, R10 interrupt gating
        set_count(16'hFFFE);
        window(3, mb(0, 3'b100, 1), mb(0, 3'b110, 1));
        chk_count(16'h0001, "R8 wrapped count");
        rd_chk(2'd3, 8'hC0, "R8 flag set");
        blk_irq_en = 1'b1; glb_irq_en = 1'b1;
        chk_irq(1'b1, "R10 all enabled");
        glb_irq_en = 1'b0;
        chk_irq(1'b0, "R10 global off");
        glb_irq_en = 1'b1; blk_irq_en = 1'b0;
        chk_irq(1'b0, "R10 block off");
        blk_irq_en = 1'b1;
        bus_write(2'd2, STOP);
        chk_irq(1'b0, "R10 local off");

        // R9 sticky, then cleared by software
        window(5, mb(0, 3'b100, 0), STOP);
        rd_chk(2'd3, 8'hC0, "R9 sticky");
        bus_write(2'd3, 8'h40);
        rd_chk(2'd3, 8'h40, "R9 sw clear");

        // R9 wrap beats a simultaneous clear
        set_count(16'hFFFF);
        bus_write(2'd2, mb(0, 3'b100, 0));
        bus_write(2'd3, 8'h40);
        bus_write(2'd2, STOP);
        rd_chk(2'd3, 8'hC0, "R9 set wins");
        chk_count(16'h0001, "R9 count");

        // R12 write replaces the increment of that cycle
        set_count(16'h0010);
        bus_write(2'd2, mb(0, 3'b100, 0));
        bus_write(2'd0, 8'h55);
        bus_write(2'd2, STOP);
        chk_count(16'h0056, "R12 write priority");

        finish_run();
    end
endmodule